// File: doc/BRIEF.md
# LCD Three-and-a-Half Digit Segment Driver

This block turns a converter result into drive signals for a direct-drive liquid crystal panel. It takes three BCD digits, a leading-one flag, a sign flag and an over-range flag, and produces seven-segment lines for the three low digits, one line that lights both segments of the leading "1", one polarity segment and a backplane square wave.

The backplane comes from a free-running divider on the oscillator clock. It toggles every `HALF_PERIOD` clocks, so its full period is twice that; the default of 400 gives 60 Hz at 48 kHz. A lit segment is driven in anti-phase with the backplane and a dark segment in phase with it. Over a whole period every segment line is therefore high for exactly half the time, and no DC builds up across the glass. The input value is registered only when the backplane rises. The display never changes in the middle of a backplane phase.

Over-range blanks the three low digits but keeps the leading one lit and the sign live. A lamp-test input overrides everything and holds every segment line at a constant high level. During lamp test the display shows 1888 with the sign on.

Top module: `lcd_digit_drive`

## Requirements
- R1: After reset the backplane is low. It toggles every `HALF_PERIOD` (default 400) clock cycles. Its first rise comes on the 400th rising clock edge after reset is released.
- R2: Outside lamp test, a dark segment line equals the backplane and a lit segment line equals its complement. Each line inverts whenever the backplane falls.
- R3: Each digit output is a 7-bit bus with bit 0 = a through bit 6 = g. The codes 0..9 light: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all, 9 abcdfg.
- R4: BCD codes 10 to 15 light no segment of that digit.
- R5: The polarity segment is lit when the registered sign input is 1 (negative).
- R6: The half-digit line is lit when the registered leading-one input is 1.
- R7: When over-range is registered, all three low digits are dark, the half-digit is lit and the sign still follows its input.
- R8: Inputs are sampled only at the clock edge that raises the backplane. Changes at any other time have no effect on the outputs until the next rise.
- R9: While lamp test is high, all 23 segment lines are held constant at 1, whatever the backplane does. The backplane keeps toggling, and the effect takes hold and releases at once.
- R10: Outside lamp test, with steady inputs, every segment line and the backplane are each high for exactly `HALF_PERIOD` of every 2*`HALF_PERIOD` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| onesBcd | input | 4 | Units digit, BCD |
| tensBcd | input | 4 | Tens digit, BCD |
| hundredsBcd | input | 4 | Hundreds digit, BCD |
| thousandsOne | input | 1 | Leading half-digit value (1 = show "1") |
| negative | input | 1 | Sign of the result, 1 = negative |
| overRange | input | 1 | Result exceeds full scale |
| lampTest | input | 1 | Force every segment on with a DC level |
| onesSeg | output | 7 | Units segments a..g (bit 0 = a) |
| tensSeg | output | 7 | Tens segments a..g (bit 0 = a) |
| hundredsSeg | output | 7 | Hundreds segments a..g (bit 0 = a) |
| halfSeg | output | 1 | Leading "1" (segments b and c together) |
| signSeg | output | 1 | Polarity segment |
| backplane | output | 1 | Backplane square wave |

## Verification
A new input value reaches the segment lines on the same clock edge that raises the backplane. The bench therefore waits for each backplane rise and samples at the following falling clock edge. It checks a second time 400 clocks later, once the backplane has fallen, to confirm the inverted phase. Lamp test acts on the outputs with no register on the way, so its checks follow the input change by one time step. Backplane timing and duty are measured by counting clock edges between transitions and over whole periods.

// File: rtl/lcd_drive_pkg.sv
package lcd_drive_pkg;

  localparam int NUM_DIGITS = 3;
  localparam int BCD_W      = 4;
  localparam int SEG_W      = 7;
  localparam int ALL_SEGS   = NUM_DIGITS * SEG_W + 2;

  // Strobes from the timing control to the datapath
  typedef struct packed {
    logic capture;   // backplane is about to rise: register new inputs
    logic bpToggle;  // backplane changes level at this edge
  } lcdStrobe_t;

  // Segment pattern, bit 0 = a ... bit 6 = g; invalid codes stay dark
  function automatic logic [SEG_W-1:0] bcdToSeg(input logic [BCD_W-1:0] code);
    logic [SEG_W-1:0] pat;
    case (code)
      4'd0:    pat = 7'b0111111;
      4'd1:    pat = 7'b0000110;
      4'd2:    pat = 7'b1011011;
      4'd3:    pat = 7'b1001111;
      4'd4:    pat = 7'b1100110;
      4'd5:    pat = 7'b1101101;
      4'd6:    pat = 7'b1111101;
      4'd7:    pat = 7'b0000111;
      4'd8:    pat = 7'b1111111;
      4'd9:    pat = 7'b1101111;
      default: pat = 7'b0000000;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/lcd_drive_ctrl.sv
module lcd_drive_ctrl
  import lcd_drive_pkg::*;
#(
  parameter int HALF_PERIOD = 400
) (
  input  logic       clk,
  input  logic       rstN,
  output lcdStrobe_t strobe,
  output logic       backplane
);

  localparam int CNT_W = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] divCnt;
  logic             wrap;

  assign wrap = (divCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      backplane <= 1'b0;
    end else if (wrap) begin
      divCnt    <= '0;
      backplane <= ~backplane;
    end else begin
      divCnt    <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.bpToggle = wrap;
    strobe.capture  = wrap & ~backplane;
  end

  // Gap monitor: clocks since the backplane last changed
  logic             bpPrev;
  logic [CNT_W:0]   edgeGap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpPrev  <= 1'b0;
      edgeGap <= '0;
    end else begin
      bpPrev  <= backplane;
      edgeGap <= (backplane != bpPrev) ? (CNT_W+1)'(1) : edgeGap + 1'b1;
    end
  end

  // R1
  bp_half_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (backplane != bpPrev) |-> (edgeGap == (CNT_W+1)'(HALF_PERIOD)));

  // R1
  bp_gap_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeGap <= (CNT_W+1)'(HALF_PERIOD));

  // R8
  capture_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> $rose(backplane));

endmodule

// File: rtl/lcd_seg_decode.sv
module lcd_seg_decode
  import lcd_drive_pkg::*;
(
  input  logic [BCD_W-1:0] bcd,
  input  logic             blank,
  output logic [SEG_W-1:0] lit
);

  always_comb begin
    lit = blank ? '0 : bcdToSeg(bcd);
  end

endmodule

// File: rtl/lcd_drive_datapath.sv
module lcd_drive_datapath
  import lcd_drive_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  lcdStrobe_t                          strobe,
  input  logic                                backplane,
  input  logic [NUM_DIGITS-1:0][BCD_W-1:0]    digitsIn,
  input  logic                                oneIn,
  input  logic                                negIn,
  input  logic                                ovrIn,
  input  logic                                lampTest,
  output logic [NUM_DIGITS-1:0][SEG_W-1:0]    segOut,
  output logic                                halfSeg,
  output logic                                signSeg
);

  logic [NUM_DIGITS-1:0][BCD_W-1:0] digitReg;
  logic                             oneReg;
  logic                             negReg;
  logic                             ovrReg;
  logic [NUM_DIGITS-1:0][SEG_W-1:0] litPat;

  // Value register, loaded only as the backplane rises
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      digitReg <= '0;
      oneReg   <= 1'b0;
      negReg   <= 1'b0;
      ovrReg   <= 1'b0;
    end else if (strobe.capture) begin
      digitReg <= digitsIn;
      oneReg   <= oneIn;
      negReg   <= negIn;
      ovrReg   <= ovrIn;
    end
  end

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    lcd_seg_decode u_dec (
      .bcd   (digitReg[i]),
      .blank (ovrReg),
      .lit   (litPat[i])
    );
    assign segOut[i] = lampTest ? {SEG_W{1'b1}} : (litPat[i] ^ {SEG_W{backplane}});
  end

  assign halfSeg = lampTest | ((oneReg | ovrReg) ^ backplane);
  assign signSeg = lampTest | (negReg ^ backplane);

  logic [ALL_SEGS-1:0] segAll;
  assign segAll = {segOut, halfSeg, signSeg};

  // R8
  hold_between_rises_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable({digitReg, oneReg, negReg, ovrReg}));

  // R2
  seg_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bpToggle && backplane && !lampTest) |=>
      (lampTest || segAll == ~$past(segAll)));

  // R7
  blank_on_overrange_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovrReg && !lampTest) |->
      (segOut == {(NUM_DIGITS*SEG_W){backplane}} && halfSeg == !backplane));

  // R9
  lamp_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lampTest && $past(lampTest)) |-> ($stable(segAll) && (&segAll)));

endmodule

// File: rtl/lcd_digit_drive.sv
module lcd_digit_drive
  import lcd_drive_pkg::*;
#(
  parameter int HALF_PERIOD = 400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BCD_W-1:0] onesBcd,
  input  logic [BCD_W-1:0] tensBcd,
  input  logic [BCD_W-1:0] hundredsBcd,
  input  logic             thousandsOne,
  input  logic             negative,
  input  logic             overRange,
  input  logic             lampTest,
  output logic [SEG_W-1:0] onesSeg,
  output logic [SEG_W-1:0] tensSeg,
  output logic [SEG_W-1:0] hundredsSeg,
  output logic             halfSeg,
  output logic             signSeg,
  output logic             backplane
);

  lcdStrobe_t                       strobe;
  logic [NUM_DIGITS-1:0][SEG_W-1:0] segOut;

  lcd_drive_ctrl #(.HALF_PERIOD(HALF_PERIOD)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .backplane (backplane)
  );

  lcd_drive_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .backplane (backplane),
    .digitsIn  ({hundredsBcd, tensBcd, onesBcd}),
    .oneIn     (thousandsOne),
    .negIn     (negative),
    .ovrIn     (overRange),
    .lampTest  (lampTest),
    .segOut    (segOut),
    .halfSeg   (halfSeg),
    .signSeg   (signSeg)
  );

  assign onesSeg     = segOut[0];
  assign tensSeg     = segOut[1];
  assign hundredsSeg = segOut[2];

endmodule

// File: tb/test_lcd_digit_drive.sv
`timescale 1ns/1ps
module test_lcd_digit_drive;

  localparam int HALF = 400;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] onesBcd = 4'd0, tensBcd = 4'd0, hundredsBcd = 4'd0;
  logic       thousandsOne = 1'b0, negative = 1'b0, overRange = 1'b0, lampTest = 1'b0;
  logic [6:0] onesSeg, tensSeg, hundredsSeg;
  logic       halfSeg, signSeg, backplane;

  int checks = 0;
  int errors = 0;

  // Model of the registered value
  logic [3:0] mO = 0, mT = 0, mH = 0;
  logic       mOne = 0, mNeg = 0, mOvr = 0;

  always #2 clk = ~clk;

  lcd_digit_drive #(.HALF_PERIOD(HALF)) i_lcd_digit_drive (
    .clk(clk), .rstN(rstN),
    .onesBcd(onesBcd), .tensBcd(tensBcd), .hundredsBcd(hundredsBcd),
    .thousandsOne(thousandsOne), .negative(negative), .overRange(overRange),
    .lampTest(lampTest),
    .onesSeg(onesSeg), .tensSeg(tensSeg), .hundredsSeg(hundredsSeg),
    .halfSeg(halfSeg), .signSeg(signSeg), .backplane(backplane)
  );

  function automatic logic [6:0] refPattern(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] expDigit(input logic [3:0] d, input logic bp);
    if (lampTest) return 7'h7F;
    return (mOvr ? 7'h00 : refPattern(d)) ^ {7{bp}};
  endfunction

  task automatic checkOuts(input string req);
    logic bp;
    bp = backplane;
    check(req, "ones",     {25'd0, onesSeg},     {25'd0, expDigit(mO, bp)});
    check(req, "tens",     {25'd0, tensSeg},     {25'd0, expDigit(mT, bp)});
    check(req, "hundreds", {25'd0, hundredsSeg}, {25'd0, expDigit(mH, bp)});
    check(req, "half",     {31'd0, halfSeg}, {31'd0, lampTest | ((mOne | mOvr) ^ bp)});
    check(req, "sign",     {31'd0, signSeg}, {31'd0, lampTest | (mNeg ^ bp)});
  endtask

  task automatic applyIn(input logic [3:0] h, input logic [3:0] t, input logic [3:0] o,
                         input logic one, input logic neg, input logic ovr);
    @(negedge clk);
    hundredsBcd = h; tensBcd = t; onesBcd = o;
    thousandsOne = one; negative = neg; overRange = ovr;
  endtask

  // Wait for the backplane to rise, update the model, sample at the next negedge
  task automatic nextRise();
    @(posedge backplane);
    mO = onesBcd; mT = tensBcd; mH = hundredsBcd;
    mOne = thousandsOne; mNeg = negative; mOvr = overRange;
    @(negedge clk);
  endtask

  task automatic bothPhases(input string req);
    nextRise();
    checkOuts(req);
    repeat (HALF) @(negedge clk);
    check(req, "low phase bp", {31'd0, backplane}, 32'd0);
    checkOuts(req);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    void'($urandom(32'd20240611));
    hundredsBcd = 4'd1; tensBcd = 4'd2; onesBcd = 4'd3;
    repeat (5) @(negedge clk);
    // R1 reset state, R3 zero pattern during reset
    check("R1", "reset bp", {31'd0, backplane}, 32'd0);
    checkOuts("R3");

    rstN = 1'b1;
    n = 0;
    while (!backplane) begin @(posedge clk); #1; n++; end
    check("R1", "clocks to first rise", n, HALF);
    mO = 4'd3; mT = 4'd2; mH = 4'd1;
    n = 0;
    while (backplane) begin @(posedge clk); #1; n++; end
    check("R1", "high phase length", n, HALF);
    @(negedge clk);
    checkOuts("R2");

    // R3: every code in every position
    for (int d = 0; d < 10; d++) begin
      applyIn(4'(d), 4'((d + 3) % 10), 4'((d + 7) % 10), 1'b0, 1'b0, 1'b0);
      bothPhases("R3");
    end

    // R4: invalid codes dark
    applyIn(4'd10, 4'd13, 4'd15, 1'b0, 1'b0, 1'b0);
    bothPhases("R4");
    applyIn(4'd11, 4'd12, 4'd14, 1'b0, 1'b0, 1'b0);
    bothPhases("R4");

    // R5, R6
    applyIn(4'd9, 4'd9, 4'd9, 1'b1, 1'b1, 1'b0);
    bothPhases("R5");
    applyIn(4'd0, 4'd5, 4'd0, 1'b1, 1'b0, 1'b0);
    bothPhases("R6");

    // R7: over-range with both signs
    applyIn(4'd8, 4'd8, 4'd8, 1'b0, 1'b1, 1'b1);
    bothPhases("R7");
    applyIn(4'd1, 4'd2, 4'd3, 1'b0, 1'b0, 1'b1);
    bothPhases("R7");

    // R8: mid-phase change must not show until the next rise
    applyIn(4'd4, 4'd5, 4'd6, 1'b0, 1'b0, 1'b0);
    nextRise();
    applyIn(4'd7, 4'd1, 4'd2, 1'b1, 1'b1, 1'b0);
    repeat (150) @(negedge clk);
    checkOuts("R8");
    repeat (400) @(negedge clk);
    checkOuts("R8");
    nextRise();
    checkOuts("R8");

    // R9: lamp test acts at once and stays constant across toggles
    repeat (100) @(negedge clk);
    lampTest = 1'b1;
    #1;
    check("R9", "lamp all", {9'd0, onesSeg, tensSeg, hundredsSeg, halfSeg, signSeg},
          {9'd0, 23'h7FFFFF});
    repeat (HALF) @(negedge clk);
    check("R9", "lamp after toggle bp", {31'd0, backplane}, 32'd0);
    checkOuts("R9");
    lampTest = 1'b0;
    #1;
    checkOuts("R9");

    // R10: duty over one full period with steady inputs
    begin
      int hiSeg, hiSign, hiBp;
      nextRise();
      hiSeg = 0; hiSign = 0; hiBp = 0;
      for (int k = 0; k < 2 * HALF; k++) begin
        hiSeg  += onesSeg[1];
        hiSign += signSeg;
        hiBp   += backplane;
        @(negedge clk);
      end
      check("R10", "segment duty", hiSeg, HALF);
      check("R10", "sign duty", hiSign, HALF);
      check("R10", "backplane duty", hiBp, HALF);
    end

    // Random mix
    for (int it = 0; it < 30; it++) begin
      logic [3:0] rh, rt, ro;
      rh = (($urandom % 8) == 0) ? 4'($urandom) : 4'($urandom % 10);
      rt = 4'($urandom % 10);
      ro = 4'($urandom % 10);
      applyIn(rh, rt, ro, 1'($urandom), 1'($urandom), (($urandom % 8) == 0));
      bothPhases(mOvr ? "R7" : "R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule